// File: doc/BRIEF.md
# Received Frame Drain Sequencer

This block empties one received frame out of a radio transceiver's receive buffer after the radio raises its interrupt line. It drives a request/response register port: address, write enable, write data, read data and a one-cycle done strobe. Through that port it first reads the interrupt status register, which clears itself when read. If the receive flag is set, the block holds off further reception. It then reads the frame length byte and the payload, followed by the link-quality and signal-strength bytes. After that it flushes the receive buffer and turns reception back on.

Payload bytes leave on a valid/ready byte stream, and the final byte is marked. A one-cycle report then gives the payload length with the two check-sequence bytes removed, the link-quality byte, the signal-strength byte and an error flag. If the status read also showed a finished transmission, a one-cycle transmit-complete pulse follows the report. An out-of-range length byte skips the buffer reads and goes straight to the flush and re-enable writes.

Top module: `rx_frame_drain`

## Requirements
- R1: After reset the block is idle: `reg_req_o`, `pl_valid_o`, `rpt_valid_o` and `tx_done_o` are all low.
- R2: While idle with `irq_i` high, the first access is a read of the status address (0x031). Bit 3 of the value read is the receive flag and bit 0 is the transmit flag. The receive flag is serviced first.
- R3: When the receive flag is set, the block writes 0x04 to the baseband control address (0x039) before it reads anything from the receive buffer.
- R4: The length byte L is read from the buffer base address 0x300. For a valid L, the bytes at 0x301 up to 0x300+L-2 are read in rising address order. Each one appears on the stream in the same order, and only the last carries `pl_last_o`. The two check-sequence bytes at 0x300+L-1 and 0x300+L are never read.
- R5: After the payload, the link-quality byte is read from 0x300+L+1 and then the signal-strength byte from 0x300+L+2.
- R6: Once the buffer has been read, the block writes 0x01 to the flush address (0x00D) and then writes 0x00 to the baseband control address. No other access comes between these two writes.
- R7: For a valid frame, `rpt_valid_o` pulses for one cycle after the re-enable write. At that pulse `rpt_len_o` = L-2, `rpt_lqi_o` and `rpt_rssi_o` carry the two bytes read, and `rpt_err_o` = 0.
- R8: A length byte below 2 or above 127 causes no payload, link-quality or signal-strength reads. The flush and re-enable writes still take place, and the report shows `rpt_err_o` = 1 with length, link quality and signal strength all 0.
- R9: When the transmit flag is set, `tx_done_o` pulses for one cycle. If both flags were set, this pulse comes after the frame report.
- R10: When neither flag is set, the status read is the only access and the block goes back to idle.
- R11: Once `reg_req_o` rises, it stays high with address, write enable and write data unchanged until the cycle in which `reg_done_i` is high.
- R12: While `pl_valid_o` is high and `pl_ready_i` is low, `pl_data_o` and `pl_last_o` hold their values. No read from the payload area is issued while a byte waits on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Radio interrupt, active high, level |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | AW | Register address |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid with done |
| reg_done_i | input | 1 | Access completes this cycle |
| pl_valid_o | output | 1 | Payload byte valid |
| pl_data_o | output | 8 | Payload byte |
| pl_last_o | output | 1 | Final payload byte of the frame |
| pl_ready_i | input | 1 | Payload sink ready |
| rpt_valid_o | output | 1 | Frame report pulse |
| rpt_err_o | output | 1 | Length byte out of range |
| rpt_len_o | output | LW | Payload length without check bytes |
| rpt_lqi_o | output | 8 | Link-quality byte |
| rpt_rssi_o | output | 8 | Signal-strength byte |
| tx_done_o | output | 1 | Transmit-complete pulse |

## Verification
The bench uses the default parameters: a 10-bit address space, buffer base 0x300 and a maximum length of 127. With these values every length byte from 0 through 131, plus 255, can be swept. The sweep covers both rejection edges, the zero-payload frame at L = 2 and the largest legal frame. Register latency changes from frame to frame, and an uneven ready pattern holds the stream back, which exercises the stall and hold rules. Frames that carry only the transmit flag, no flag, or unrelated status bits cover the remaining branches.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ISR, ST_DIS, ST_LEN, ST_PAY, ST_LQI,
      ST_RSSI, ST_FLUSH, ST_EN, ST_RPT, ST_TX
   } rxd_state_e;

   function automatic logic is_access(rxd_state_e s);
      return (s != ST_IDLE) && (s != ST_RPT) && (s != ST_TX);
   endfunction
endpackage

// File: rtl/rxd_addr_gen.sv
module rxd_addr_gen
   import rxd_pkg::*;
#(
   parameter int AW         = 10,
   parameter int LW         = 7,
   parameter int RX_BASE    = 'h300,
   parameter int STAT_ADDR  = 'h031,
   parameter int BBCTL_ADDR = 'h039,
   parameter int FLUSH_ADDR = 'h00D,
   parameter int HOLD_VAL   = 'h04
) (
   input  rxd_state_e    state_i,
   input  logic [LW-1:0] idx_i,
   input  logic [7:0]    flen_i,
   output logic [AW-1:0] addr_o,
   output logic          we_o,
   output logic [7:0]    wdata_o
);
   localparam logic [AW-1:0] BASE_W  = AW'(RX_BASE);
   localparam logic [AW-1:0] STAT_W  = AW'(STAT_ADDR);
   localparam logic [AW-1:0] BBCTL_W = AW'(BBCTL_ADDR);
   localparam logic [AW-1:0] FLUSH_W = AW'(FLUSH_ADDR);

   always_comb begin
      addr_o  = STAT_W;
      we_o    = 1'b0;
      wdata_o = 8'h00;
      unique case (state_i)
         ST_DIS:   begin addr_o = BBCTL_W; we_o = 1'b1; wdata_o = 8'(HOLD_VAL); end
         ST_LEN:   addr_o = BASE_W;
         ST_PAY:   addr_o = BASE_W + AW'(idx_i) + AW'(1);
         ST_LQI:   addr_o = BASE_W + AW'(flen_i) + AW'(1);
         ST_RSSI:  addr_o = BASE_W + AW'(flen_i) + AW'(2);
         ST_FLUSH: begin addr_o = FLUSH_W; we_o = 1'b1; wdata_o = 8'h01; end
         ST_EN:    begin addr_o = BBCTL_W; we_o = 1'b1; wdata_o = 8'h00; end
         default:  addr_o = STAT_W;
      endcase
   end
endmodule

// File: rtl/rxd_stream_reg.sv
module rxd_stream_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] din_i,
   input  logic          dlast_i,
   output logic          valid_o,
   output logic [DW-1:0] data_o,
   output logic          last_o,
   input  logic          ready_i
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         last_o  <= 1'b0;
      end else if (push_i) begin
         valid_o <= 1'b1;
         data_o  <= din_i;
         last_o  <= dlast_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o))
      else $error("stream byte changed while stalled");
endmodule

// File: rtl/rx_frame_drain.sv
module rx_frame_drain
   import rxd_pkg::*;
#(
   parameter int AW         = 10,
   parameter int RX_BASE    = 'h300,
   parameter int STAT_ADDR  = 'h031,
   parameter int BBCTL_ADDR = 'h039,
   parameter int FLUSH_ADDR = 'h00D,
   parameter int HOLD_VAL   = 'h04,
   parameter int RX_BIT     = 3,
   parameter int TX_BIT     = 0,
   parameter int FCS_BYTES  = 2,
   parameter int MAX_LEN    = 127,
   localparam int LW        = $clog2(MAX_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_i,
   output logic          reg_req_o,
   output logic          reg_we_o,
   output logic [AW-1:0] reg_addr_o,
   output logic [7:0]    reg_wdata_o,
   input  logic [7:0]    reg_rdata_i,
   input  logic          reg_done_i,
   output logic          pl_valid_o,
   output logic [7:0]    pl_data_o,
   output logic          pl_last_o,
   input  logic          pl_ready_i,
   output logic          rpt_valid_o,
   output logic          rpt_err_o,
   output logic [LW-1:0] rpt_len_o,
   output logic [7:0]    rpt_lqi_o,
   output logic [7:0]    rpt_rssi_o,
   output logic          tx_done_o
);
   if (RX_BIT == TX_BIT || RX_BIT > 7 || TX_BIT > 7) begin : g_bad_flags
      $error("status flag positions must differ and lie in one byte");
   end
   if (MAX_LEN > 255 || MAX_LEN <= FCS_BYTES) begin : g_bad_len
      $error("MAX_LEN must fit the length byte and exceed FCS_BYTES");
   end
   if (RX_BASE + MAX_LEN + 3 > (1 << AW)) begin : g_bad_aw
      $error("receive buffer does not fit the address width");
   end

   rxd_state_e    state_q;
   logic          rx_flag_q, tx_flag_q, err_q;
   logic [7:0]    flen_q, lqi_q, rssi_q;
   logic [LW-1:0] idx_q, plen;
   logic          len_bad, push, last_byte;

   assign plen      = LW'(flen_q - 8'(FCS_BYTES));
   assign len_bad   = (reg_rdata_i < 8'(FCS_BYTES)) || (reg_rdata_i > 8'(MAX_LEN));
   assign last_byte = (idx_q == plen - LW'(1));
   assign push      = (state_q == ST_PAY) && reg_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rx_flag_q <= 1'b0;
         tx_flag_q <= 1'b0;
         err_q     <= 1'b0;
         flen_q    <= '0;
         lqi_q     <= '0;
         rssi_q    <= '0;
         idx_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (irq_i) state_q <= ST_ISR;
            ST_ISR: if (reg_done_i) begin
               rx_flag_q <= reg_rdata_i[RX_BIT];
               tx_flag_q <= reg_rdata_i[TX_BIT];
               if (reg_rdata_i[RX_BIT])      state_q <= ST_DIS;
               else if (reg_rdata_i[TX_BIT]) state_q <= ST_TX;
               else                          state_q <= ST_IDLE;
            end
            ST_DIS: if (reg_done_i) state_q <= ST_LEN;
            ST_LEN: if (reg_done_i) begin
               flen_q <= reg_rdata_i;
               idx_q  <= '0;
               lqi_q  <= '0;
               rssi_q <= '0;
               err_q  <= len_bad;
               if (len_bad)                              state_q <= ST_FLUSH;
               else if (reg_rdata_i == 8'(FCS_BYTES))    state_q <= ST_LQI;
               else                                      state_q <= ST_PAY;
            end
            ST_PAY: if (reg_done_i) begin
               idx_q <= idx_q + LW'(1);
               if (last_byte) state_q <= ST_LQI;
            end
            ST_LQI: if (reg_done_i) begin
               lqi_q   <= reg_rdata_i;
               state_q <= ST_RSSI;
            end
            ST_RSSI: if (reg_done_i) begin
               rssi_q  <= reg_rdata_i;
               state_q <= ST_FLUSH;
            end
            ST_FLUSH: if (reg_done_i) state_q <= ST_EN;
            ST_EN:    if (reg_done_i) state_q <= ST_RPT;
            ST_RPT:   state_q <= tx_flag_q ? ST_TX : ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign reg_req_o   = is_access(state_q) && !((state_q == ST_PAY) && pl_valid_o);
   assign rpt_valid_o = (state_q == ST_RPT);
   assign rpt_err_o   = err_q;
   assign rpt_len_o   = err_q ? '0 : plen;
   assign rpt_lqi_o   = lqi_q;
   assign rpt_rssi_o  = rssi_q;
   assign tx_done_o   = (state_q == ST_TX);

   rxd_addr_gen #(
      .AW(AW), .LW(LW), .RX_BASE(RX_BASE), .STAT_ADDR(STAT_ADDR),
      .BBCTL_ADDR(BBCTL_ADDR), .FLUSH_ADDR(FLUSH_ADDR), .HOLD_VAL(HOLD_VAL)
   ) u_addr (
      .state_i(state_q), .idx_i(idx_q), .flen_i(flen_q),
      .addr_o(reg_addr_o), .we_o(reg_we_o), .wdata_o(reg_wdata_o)
   );

   rxd_stream_reg #(.DW(8)) u_stream (
      .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(reg_rdata_i),
      .dlast_i(last_byte), .valid_o(pl_valid_o), .data_o(pl_data_o),
      .last_o(pl_last_o), .ready_i(pl_ready_i)
   );

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && !reg_done_i |=> reg_req_o && $stable(reg_addr_o)
                                   && $stable(reg_we_o) && $stable(reg_wdata_o))
      else $error("request dropped or changed before done");

   p_no_read_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAY) && pl_valid_o |-> !reg_req_o)
      else $error("payload read issued while stream stalled");

   p_flush_then_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLUSH) && reg_done_i |=> reg_req_o && reg_we_o
                                             && (reg_wdata_o == 8'h00))
      else $error("re-enable write does not follow flush");

   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o && rpt_err_o |-> (rpt_len_o == '0) && (rpt_lqi_o == 8'h00)
                                   && (rpt_rssi_o == 8'h00))
      else $error("error report carries nonzero fields");

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rpt_valid_o, tx_done_o, reg_req_o}))
      else $error("report, tx pulse and access overlap");

   p_tx_after_rpt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o && tx_flag_q |=> tx_done_o)
      else $error("tx pulse missing after report");
endmodule

// File: tb/rx_frame_drain_test.sv
module rx_frame_drain_test;
   localparam int AW = 10;
   localparam int BASE = 'h300;
   localparam int STAT = 'h031;
   localparam int BBC = 'h039;
   localparam int FLU = 'h00D;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, irq, reg_done, pl_ready;
   logic [7:0] reg_rdata;
   logic reg_req, reg_we, pl_valid, pl_last, rpt_valid, rpt_err, tx_done;
   logic [AW-1:0] reg_addr;
   logic [7:0] reg_wdata, pl_data, rpt_lqi, rpt_rssi;
   logic [6:0] rpt_len;

   rx_frame_drain uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq),
      .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
      .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .reg_done_i(reg_done),
      .pl_valid_o(pl_valid), .pl_data_o(pl_data), .pl_last_o(pl_last),
      .pl_ready_i(pl_ready), .rpt_valid_o(rpt_valid), .rpt_err_o(rpt_err),
      .rpt_len_o(rpt_len), .rpt_lqi_o(rpt_lqi), .rpt_rssi_o(rpt_rssi),
      .tx_done_o(tx_done)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [7:0] mem [0:1023];
   logic [7:0] status_v;
   int lat = 1, cnt = 0, cur_len = 0;
   int tr_n = 0;
   int tr_addr [0:299];
   int tr_we [0:299];
   int tr_dat [0:299];
   int ex_n;
   int ex_addr [0:299];
   int ex_we [0:299];
   int ex_dat [0:299];
   int pay_n = 0, last_bad = 0;
   logic [7:0] pay [0:299];
   int rpt_cnt = 0, tx_cnt = 0, rpt_cyc = 0, tx_cyc = 0;
   logic r_err;
   logic [6:0] r_len;
   logic [7:0] r_lqi, r_rssi;
   int stall_viol = 0, hold_viol = 0, req_viol = 0;
   logic p_valid = 0, p_ready = 0, p_last = 0, p_req = 0, p_done = 0, p_we = 0;
   logic [7:0] p_data = 0, p_wd = 0;
   logic [AW-1:0] p_addr = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // radio register model, payload sink and monitors
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // R11 hold monitor
         if (p_req && !p_done &&
             (!reg_req || reg_addr != p_addr || reg_we != p_we || reg_wdata != p_wd))
            req_viol++;
         // R12 hold monitor
         if (p_valid && !p_ready && (!pl_valid || pl_data != p_data || pl_last != p_last))
            hold_viol++;
         if (reg_req && pl_valid && int'(reg_addr) >= BASE + 1 &&
             int'(reg_addr) <= BASE + cur_len - 2)
            stall_viol++;
         if (rpt_valid) begin
            rpt_cnt++; rpt_cyc = cyc;
            r_err = rpt_err; r_len = rpt_len; r_lqi = rpt_lqi; r_rssi = rpt_rssi;
         end
         if (tx_done) begin tx_cnt++; tx_cyc = cyc; end
      end
      p_req = reg_req; p_addr = reg_addr; p_we = reg_we; p_wd = reg_wdata;
      p_valid = pl_valid; p_data = pl_data; p_last = pl_last;
      // register responder
      if (!rst_n || reg_done) begin
         reg_done = 1'b0;
         cnt = 0;
      end else if (reg_req) begin
         cnt++;
         if (cnt >= lat) begin
            cnt = 0;
            reg_done = 1'b1;
            if (tr_n < 300) begin
               tr_addr[tr_n] = int'(reg_addr);
               tr_we[tr_n] = int'(reg_we);
               tr_dat[tr_n] = reg_we ? int'(reg_wdata) : 0;
               tr_n++;
            end
            if (!reg_we) begin
               if (int'(reg_addr) == STAT) begin
                  reg_rdata = status_v;
                  status_v = 8'h00;
                  irq = 1'b0;
               end else reg_rdata = mem[reg_addr];
            end
         end
      end
      p_done = reg_done;
      // payload sink with an uneven ready pattern
      pl_ready = ((cyc * 3 + cur_len) % 7) < 3;
      p_ready = pl_ready;
      if (rst_n && pl_valid && pl_ready) begin
         if (pay_n < 300) pay[pay_n] = pl_data;
         if (pl_last != (pay_n == cur_len - 3)) last_bad++;
         pay_n++;
      end
   end

   task automatic ex_add(input int a, input int w, input int d);
      ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_dat[ex_n] = d; ex_n++;
   endtask

   task automatic run_frame(input int len, input logic [7:0] st);
      bit rx, tx, good;
      int mism, plen;
      string rq;
      rx = st[3]; tx = st[0];
      good = (len >= 2) && (len <= 127);
      plen = good ? len - 2 : 0;
      lat = 1 + (len % 3);
      for (int i = 0; i < 260; i++) mem[BASE + i] = 8'((len * 7 + i * 13) & 255);
      mem[BASE] = 8'(len);
      @(negedge clk);
      cur_len = len; tr_n = 0; pay_n = 0; last_bad = 0;
      rpt_cnt = 0; tx_cnt = 0; rpt_cyc = 0; tx_cyc = 0;
      status_v = st;
      irq = 1'b1;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (!irq && !reg_req && !pl_valid && rpt_cnt == int'(rx) &&
             tx_cnt == int'(tx)) break;
      end
      repeat (6) @(negedge clk);
      // expected access trace
      ex_n = 0;
      ex_add(STAT, 0, 0);
      if (rx) begin
         ex_add(BBC, 1, 4);
         ex_add(BASE, 0, 0);
         if (good) begin
            for (int i = 0; i < plen; i++) ex_add(BASE + 1 + i, 0, 0);
            ex_add(BASE + len + 1, 0, 0);
            ex_add(BASE + len + 2, 0, 0);
         end
         ex_add(FLU, 1, 1);
         ex_add(BBC, 1, 0);
      end
      mism = -1;
      for (int i = 0; i < ex_n && i < tr_n; i++)
         if (mism < 0 && (tr_addr[i] != ex_addr[i] || tr_we[i] != ex_we[i] ||
                          tr_dat[i] != ex_dat[i])) mism = i;
      rq = !rx ? (tx ? "R9" : "R10") : (good ? "R2/R3/R4/R5/R6" : "R8");
      chk(tr_n == ex_n, rq, $sformatf("access count len=%0d st=%0h", len, st), tr_n, ex_n);
      if (mism >= 0)
         chk(0, rq, $sformatf("access %0d address len=%0d", mism, len),
             tr_addr[mism], ex_addr[mism]);
      else chk(1, rq, "access order", 0, 0);
      if (rx) begin
         // R4 payload content and last marker
         chk(pay_n == plen, "R4", $sformatf("payload bytes len=%0d", len), pay_n, plen);
         mism = -1;
         for (int i = 0; i < plen && i < pay_n; i++)
            if (mism < 0 && pay[i] != mem[BASE + 1 + i]) mism = i;
         if (mism >= 0)
            chk(0, "R4", $sformatf("payload byte %0d", mism), pay[mism], mem[BASE + 1 + mism]);
         chk(last_bad == 0, "R4", "last marker placement", last_bad, 0);
         chk(rpt_cnt == 1, good ? "R7" : "R8", "report pulses", rpt_cnt, 1);
         if (good) begin
            chk(r_err == 0 && r_len == 7'(plen), "R7", $sformatf("report length len=%0d", len),
                int'(r_len), plen);
            chk(r_lqi == mem[BASE + len + 1] && r_rssi == mem[BASE + len + 2], "R7",
                "report lqi/rssi", int'({r_lqi, r_rssi}),
                int'({mem[BASE + len + 1], mem[BASE + len + 2]}));
         end else begin
            chk(r_err == 1 && r_len == 0 && r_lqi == 0 && r_rssi == 0, "R8",
                $sformatf("error report len=%0d", len), int'({r_err, r_len, r_lqi, r_rssi}),
                int'({1'b1, 7'd0, 16'd0}));
         end
      end else begin
         chk(pay_n == 0 && rpt_cnt == 0, tx ? "R9" : "R10", "no frame output",
             pay_n + rpt_cnt, 0);
      end
      chk(tx_cnt == int'(tx), "R9", $sformatf("tx pulses st=%0h", st), tx_cnt, int'(tx));
      if (rx && tx)
         chk(tx_cyc == rpt_cyc + 1, "R9", "tx pulse right after report", tx_cyc, rpt_cyc + 1);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i);
      rst_n = 1'b0; irq = 1'b0; reg_done = 1'b0; reg_rdata = 8'h00;
      pl_ready = 1'b0; status_v = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!reg_req && !pl_valid && !rpt_valid && !tx_done, "R1", "idle in reset",
          int'({reg_req, pl_valid, rpt_valid, tx_done}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!reg_req && !pl_valid && !rpt_valid && !tx_done, "R1", "idle after reset",
          int'({reg_req, pl_valid, rpt_valid, tx_done}), 0);
      for (int len = 0; len <= 131; len++) run_frame(len, (len % 2) ? 8'h09 : 8'h08);
      run_frame(255, 8'h08);
      run_frame(40, 8'hFF);
      run_frame(10, 8'h01);
      run_frame(10, 8'h00);
      run_frame(10, 8'hF6);
      chk(req_viol == 0, "R11", "request held until done", req_viol, 0);
      chk(hold_viol == 0, "R12", "stream byte held while stalled", hold_viol, 0);
      chk(stall_viol == 0, "R12", "no payload read while byte waits", stall_viol, 0);
      summary();
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule